// File: doc/BRIEF.md
# Temperature Sensor Register Slave on a Two-Wire Bus

This block is the serial front of a digital temperature sensor. It watches oversampled SCL and SDA lines and finds START, repeated START and STOP conditions. It answers to one seven-bit device address and drives the data line low through an open-drain enable, both to acknowledge and to send read data. A sticky register pointer picks one of four registers: the live temperature value, which is read-only, a one-byte configuration, a low limit and a high limit.

The neighbouring conversion and alert logic consumes the block's outputs. These are the configuration and both limits, a strobe on each configuration write, and a one-cycle pulse for every read data byte, which the alert logic can use as a clear. A general-call command restores the power-up values and raises a reset strobe for the neighbours. A stuck-low bus watchdog drops any transaction that stalls.

Top module: `tsense_twi_slave`

## Requirements
- R1: The device answers, with an acknowledge, only the address whose upper six bits are 100100 and whose last bit equals the address pin. The pin is latched at reset, at each START and by a general-call latch or reset command. Any other non-zero address gets no acknowledge, and SDA is left released.
- R2: In a write, the byte after the address is the pointer. Its bits [1:0] select the register: 00 temperature, 01 configuration, 10 low limit, 11 high limit. After reset the pointer is 00.
- R3: A read uses the pointer from the most recent write. Repeated reads return the same register without a new pointer byte.
- R4: A 12-bit register moves as two bytes, most significant byte first. The first byte carries bits [11:4] and the second carries bits [3:0] in its upper nibble, with the lower nibble zero. A limit register is updated only when its second byte arrives.
- R5: The slave acknowledges its address, the pointer and every written byte. In a read, a master NACK ends the transfer and SDA is released.
- R6: A write to the temperature register changes nothing. A read takes both bytes of a register from one snapshot made when the first byte is loaded.
- R7: The configuration register is one byte, written from the first data byte. Bit 7 always reads back as 0. Each configuration write raises cfg_wr_o for one cycle.
- R8: The power-up values are configuration 0x00, low limit 0x4B0 and high limit 0x500. A general call (address 0000000, write) followed by 0x06 restores them, clears the pointer and pulses gc_reset_o. A general call followed by 0x04 only re-latches the address pin.
- R9: If SCL stays low, or SDA stays low with SCL stopped, for TIMEOUT_CYCLES clocks inside a transaction, the slave releases SDA and waits for a new START.
- R10: rd_pulse_o pulses for exactly one cycle each time a read data byte has been shifted out.
- R11: The slave starts to pull SDA low only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| addr_pin_i | input | 1 | Address select pin |
| temp_i | input | TEMP_W | Latest converted temperature, two's complement |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| cfg_o | output | 8 | Configuration register |
| tlow_o | output | TEMP_W | Low limit register |
| thigh_o | output | TEMP_W | High limit register |
| cfg_wr_o | output | 1 | One-cycle strobe on configuration write |
| rd_pulse_o | output | 1 | One-cycle pulse per read data byte sent |
| gc_reset_o | output | 1 | One-cycle strobe on general-call reset |

## Verification
The checker watches four rules on every cycle. SDA must only start being driven while SCL is low. The configuration may change only after a configuration write or a general-call reset. The power-up values must be present right after a reset strobe. Read pulses and timeouts each last one cycle, and SDA must be released after a timeout. The bench scenarios cover the behaviour that needs whole transactions. These are address match and mismatch, pointer stickiness, byte order and nibble justification, the ignored temperature write, snapshot consistency across a temperature change between the two bytes, both general-call commands, and recovery after the stuck-bus timeout.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  localparam int BYTE_W = 8;
  localparam logic [1:0] SEL_TEMP = 2'b00;
  localparam logic [1:0] SEL_CFG  = 2'b01;
  localparam logic [1:0] SEL_LO   = 2'b10;
  localparam logic [1:0] SEL_HI   = 2'b11;
  localparam logic [5:0] ADDR_STEM = 6'b100100;
  localparam logic [7:0] GC_LATCH = 8'h04;
  localparam logic [7:0] GC_RESET = 8'h06;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK
  } link_st_e;
endpackage

// File: rtl/tsi_sync.sv
module tsi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic q,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              last;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b1;
        else     chain[0] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= 1'b1;
        else     chain[i] <= chain[i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) last <= 1'b1;
    else     last <= chain[STAGES-1];
  end

  assign q    = chain[STAGES-1];
  assign rise = q & ~last;
  assign fall = ~q & last;
endmodule

// File: rtl/tsi_regs.sv
module tsi_regs
  import tsi_pkg::*;
#(
  parameter int W = 12,
  parameter logic [W-1:0] LO_RESET = 12'h4B0,
  parameter logic [W-1:0] HI_RESET = 12'h500
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [BYTE_W-1:0] wr_hi,
  input  logic [W-BYTE_W-1:0] wr_lo,
  input  logic [W-1:0]      temp_i,
  input  logic [1:0]        rd_sel,
  output logic [BYTE_W-1:0] rd_msb,
  output logic [BYTE_W-1:0] rd_lsb,
  output logic [BYTE_W-1:0] cfg_o,
  output logic [W-1:0]      lo_o,
  output logic [W-1:0]      hi_o
);
  localparam int LO_W  = W - BYTE_W;
  localparam int PAD_W = 2*BYTE_W - W;

  logic [W-1:0] word;

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      cfg_o <= '0;
      lo_o  <= LO_RESET;
      hi_o  <= HI_RESET;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_CFG: cfg_o <= wr_hi;
        SEL_LO:  lo_o  <= {wr_hi, wr_lo};
        SEL_HI:  hi_o  <= {wr_hi, wr_lo};
        default: ;
      endcase
    end
  end

  always_comb begin
    case (rd_sel)
      SEL_LO:  word = lo_o;
      SEL_HI:  word = hi_o;
      default: word = temp_i;
    endcase
    if (rd_sel == SEL_CFG) begin
      rd_msb = {1'b0, cfg_o[BYTE_W-2:0]};
      rd_lsb = {1'b0, cfg_o[BYTE_W-2:0]};
    end else begin
      rd_msb = word[W-1 -: BYTE_W];
      rd_lsb = {word[LO_W-1:0], {PAD_W{1'b0}}};
    end
  end
endmodule

// File: rtl/tsi_link.sv
module tsi_link
  import tsi_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 2_700_000,
  parameter int LO_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl,
  input  logic              sda,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_rise,
  input  logic              sda_fall,
  input  logic              addr_pin,
  input  logic [BYTE_W-1:0] rd_msb,
  input  logic [BYTE_W-1:0] rd_lsb,
  output logic [1:0]        rd_sel,
  output logic              wr_en,
  output logic [1:0]        wr_sel,
  output logic [BYTE_W-1:0] wr_hi,
  output logic [LO_W-1:0]   wr_lo,
  output logic              cfg_wr,
  output logic              rd_pulse,
  output logic              gc_rst,
  output logic              sda_oe,
  output logic              timeout
);
  localparam int TO_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [TO_W-1:0] TO_MAX = TO_W'(TIMEOUT_CYCLES);
  localparam logic [2:0] BIDX_MAX = 3'd4;

  link_st_e          st;
  logic [3:0]        bitcnt;
  logic [2:0]        bidx;
  logic [BYTE_W-1:0] rx_sr, tx_sr, lsb_hold, msb_hold;
  logic              lsb_next, is_rd, is_gc, a0_lat;
  logic [1:0]        ptr;
  logic [TO_W-1:0]   to_cnt;

  logic              start_ev, stop_ev, to_hit, addr_match;
  logic [BYTE_W-1:0] next_tx;

  assign start_ev   = scl & sda_fall;
  assign stop_ev    = scl & sda_rise;
  assign to_hit     = (st != ST_IDLE) && (to_cnt == TO_MAX);
  assign addr_match = (rx_sr[7:1] == {ADDR_STEM, a0_lat});
  assign next_tx    = lsb_next ? lsb_hold : rd_msb;
  assign rd_sel     = ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      bitcnt   <= '0;
      bidx     <= '0;
      rx_sr    <= '0;
      tx_sr    <= '0;
      lsb_hold <= '0;
      msb_hold <= '0;
      lsb_next <= 1'b0;
      is_rd    <= 1'b0;
      is_gc    <= 1'b0;
      a0_lat   <= addr_pin;
      ptr      <= SEL_TEMP;
      to_cnt   <= '0;
      sda_oe   <= 1'b0;
      wr_en    <= 1'b0;
      wr_sel   <= '0;
      wr_hi    <= '0;
      wr_lo    <= '0;
      cfg_wr   <= 1'b0;
      rd_pulse <= 1'b0;
      gc_rst   <= 1'b0;
      timeout  <= 1'b0;
    end else begin
      wr_en    <= 1'b0;
      cfg_wr   <= 1'b0;
      rd_pulse <= 1'b0;
      gc_rst   <= 1'b0;
      timeout  <= 1'b0;

      // stuck-line watchdog: cleared by clock activity or an idle bus
      if (st == ST_IDLE || scl_rise || scl_fall || (scl && sda))
        to_cnt <= '0;
      else if (to_cnt != TO_MAX)
        to_cnt <= to_cnt + 1'b1;

      if (start_ev) begin
        st     <= ST_RX;
        bitcnt <= '0;
        bidx   <= '0;
        is_gc  <= 1'b0;
        is_rd  <= 1'b0;
        sda_oe <= 1'b0;
        a0_lat <= addr_pin;
      end else if (stop_ev) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (to_hit) begin
        st      <= ST_IDLE;
        sda_oe  <= 1'b0;
        timeout <= 1'b1;
        to_cnt  <= '0;
      end else begin
        case (st)
          ST_RX: begin
            if (scl_rise && bitcnt != 4'd8) begin
              rx_sr  <= {rx_sr[6:0], sda};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              if (bidx != BIDX_MAX) bidx <= bidx + 3'd1;
              if (bidx == 3'd0) begin
                if (addr_match) begin
                  st       <= ST_RX_ACK;
                  sda_oe   <= 1'b1;
                  is_rd    <= rx_sr[0];
                  tx_sr    <= rd_msb;
                  lsb_hold <= rd_lsb;
                  lsb_next <= 1'b1;
                end else if (rx_sr == 8'h00) begin
                  st     <= ST_RX_ACK;
                  sda_oe <= 1'b1;
                  is_gc  <= 1'b1;
                end else begin
                  st <= ST_IDLE;
                end
              end else if (is_gc) begin
                if (bidx == 3'd1) begin
                  st     <= ST_RX_ACK;
                  sda_oe <= 1'b1;
                  if (rx_sr == GC_LATCH || rx_sr == GC_RESET) a0_lat <= addr_pin;
                  if (rx_sr == GC_RESET) begin
                    gc_rst <= 1'b1;
                    ptr    <= SEL_TEMP;
                  end
                end else begin
                  st <= ST_IDLE;
                end
              end else begin
                st     <= ST_RX_ACK;
                sda_oe <= 1'b1;
                if (bidx == 3'd1) begin
                  ptr <= rx_sr[1:0];
                end else if (bidx == 3'd2) begin
                  msb_hold <= rx_sr;
                  if (ptr == SEL_CFG) begin
                    wr_en  <= 1'b1;
                    wr_sel <= ptr;
                    wr_hi  <= rx_sr;
                    cfg_wr <= 1'b1;
                  end
                end else if (bidx == 3'd3 && (ptr == SEL_LO || ptr == SEL_HI)) begin
                  wr_en  <= 1'b1;
                  wr_sel <= ptr;
                  wr_hi  <= msb_hold;
                  wr_lo  <= rx_sr[7 -: LO_W];
                end
              end
            end
          end
          ST_RX_ACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (is_rd) begin
                st     <= ST_TX;
                sda_oe <= ~tx_sr[7];
              end else begin
                st     <= ST_RX;
                sda_oe <= 1'b0;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bitcnt == 4'd7) begin
                sda_oe   <= 1'b0;
                st       <= ST_TX_ACK;
                rd_pulse <= 1'b1;
              end else begin
                tx_sr  <= {tx_sr[6:0], 1'b0};
                sda_oe <= ~tx_sr[6];
                bitcnt <= bitcnt + 4'd1;
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise && sda) begin
              st <= ST_IDLE;
            end else if (scl_fall) begin
              tx_sr    <= next_tx;
              sda_oe   <= ~next_tx[7];
              if (!lsb_next) lsb_hold <= rd_lsb;
              lsb_next <= ~lsb_next;
              bitcnt   <= '0;
              st       <= ST_TX;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/tsense_twi_slave.sv
module tsense_twi_slave
  import tsi_pkg::*;
#(
  parameter int SYNC_STAGES    = 2,
  parameter int TIMEOUT_CYCLES = 2_700_000,
  parameter int TEMP_W         = 12,
  parameter logic [TEMP_W-1:0] LOW_RESET  = 12'h4B0,
  parameter logic [TEMP_W-1:0] HIGH_RESET = 12'h500
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              addr_pin_i,
  input  logic [TEMP_W-1:0] temp_i,
  output logic              sda_oe_o,
  output logic [7:0]        cfg_o,
  output logic [TEMP_W-1:0] tlow_o,
  output logic [TEMP_W-1:0] thigh_o,
  output logic              cfg_wr_o,
  output logic              rd_pulse_o,
  output logic              gc_reset_o
);
  localparam int LO_W = TEMP_W - BYTE_W;

  logic scl_s, scl_r, scl_f;
  logic sda_s, sda_r, sda_f;
  logic [1:0] rd_sel, wr_sel;
  logic wr_en, bus_timeout;
  logic [BYTE_W-1:0] rd_msb, rd_lsb, wr_hi;
  logic [LO_W-1:0] wr_lo;

  tsi_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk(clk), .rst(rst), .din(scl_i), .q(scl_s), .rise(scl_r), .fall(scl_f)
  );

  tsi_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk(clk), .rst(rst), .din(sda_i), .q(sda_s), .rise(sda_r), .fall(sda_f)
  );

  tsi_link #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES), .LO_W(LO_W)) u_link (
    .clk(clk), .rst(rst),
    .scl(scl_s), .sda(sda_s),
    .scl_rise(scl_r), .scl_fall(scl_f), .sda_rise(sda_r), .sda_fall(sda_f),
    .addr_pin(addr_pin_i),
    .rd_msb(rd_msb), .rd_lsb(rd_lsb), .rd_sel(rd_sel),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_hi(wr_hi), .wr_lo(wr_lo),
    .cfg_wr(cfg_wr_o), .rd_pulse(rd_pulse_o), .gc_rst(gc_reset_o),
    .sda_oe(sda_oe_o), .timeout(bus_timeout)
  );

  tsi_regs #(.W(TEMP_W), .LO_RESET(LOW_RESET), .HI_RESET(HIGH_RESET)) u_regs (
    .clk(clk), .rst(rst), .soft_rst(gc_reset_o),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_hi(wr_hi), .wr_lo(wr_lo),
    .temp_i(temp_i), .rd_sel(rd_sel),
    .rd_msb(rd_msb), .rd_lsb(rd_lsb),
    .cfg_o(cfg_o), .lo_o(tlow_o), .hi_o(thigh_o)
  );
endmodule

// File: rtl/tsense_twi_chk.sv
module tsense_twi_chk #(
  parameter int TEMP_W = 12,
  parameter logic [TEMP_W-1:0] LOW_RESET  = 12'h4B0,
  parameter logic [TEMP_W-1:0] HIGH_RESET = 12'h500
) (
  input logic              clk,
  input logic              rst,
  input logic              scl_s,
  input logic              sda_oe_o,
  input logic              rd_pulse_o,
  input logic              gc_reset_o,
  input logic              cfg_wr_o,
  input logic              bus_timeout,
  input logic [7:0]        cfg_o,
  input logic [TEMP_W-1:0] tlow_o,
  input logic [TEMP_W-1:0] thigh_o
);
  // R11
  drive_on_low_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe_o) |-> !scl_s);

  // R8
  gc_restore_chk: assert property (@(posedge clk) disable iff (rst)
    gc_reset_o |=> (cfg_o == 8'h00 && tlow_o == LOW_RESET && thigh_o == HIGH_RESET));

  // R7
  cfg_source_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg_o) |-> ($past(cfg_wr_o) || $past(gc_reset_o)));

  // R10
  rd_single_chk: assert property (@(posedge clk) disable iff (rst)
    rd_pulse_o |=> !rd_pulse_o);

  // R9
  timeout_release_chk: assert property (@(posedge clk) disable iff (rst)
    bus_timeout |=> (!sda_oe_o && !bus_timeout));
endmodule

bind tsense_twi_slave tsense_twi_chk #(
  .TEMP_W(TEMP_W), .LOW_RESET(LOW_RESET), .HIGH_RESET(HIGH_RESET)
) u_chk (
  .clk(clk), .rst(rst), .scl_s(scl_s), .sda_oe_o(sda_oe_o),
  .rd_pulse_o(rd_pulse_o), .gc_reset_o(gc_reset_o), .cfg_wr_o(cfg_wr_o),
  .bus_timeout(bus_timeout), .cfg_o(cfg_o), .tlow_o(tlow_o), .thigh_o(thigh_o)
);

// File: tb/tb_tsense_twi_slave.sv
module tb_tsense_twi_slave;
  localparam int TO = 100;
  localparam int H  = 10;
  localparam int NV = 6;
  // {pointer, write data, expected read word}
  localparam logic [33:0] VEC [0:NV-1] = '{
    {2'd1, 16'hFF00, 16'h7F7F},
    {2'd2, 16'h1234, 16'h1230},
    {2'd3, 16'hE70F, 16'hE700},
    {2'd0, 16'hABCD, 16'h1900},
    {2'd1, 16'h0500, 16'h0505},
    {2'd2, 16'hC90F, 16'hC900}
  };

  logic clk = 0, rst = 1;
  logic scl_m = 1, sda_m = 1, addr_pin = 0;
  logic [11:0] temp = 12'h190;
  logic sda_oe, cfg_wr, rd_pulse, gc_reset;
  logic [7:0] cfg;
  logic [11:0] tlow, thigh;
  wire sda_line = sda_m & ~sda_oe;
  logic [6:0] dev_addr = 7'h48;

  int n_chk = 0, n_err = 0;
  int cnt_rd = 0, cnt_cfg = 0, cnt_gc = 0;

  always #2 clk = ~clk;

  tsense_twi_slave #(.TIMEOUT_CYCLES(TO)) dut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .addr_pin_i(addr_pin),
    .temp_i(temp), .sda_oe_o(sda_oe), .cfg_o(cfg), .tlow_o(tlow), .thigh_o(thigh),
    .cfg_wr_o(cfg_wr), .rd_pulse_o(rd_pulse), .gc_reset_o(gc_reset)
  );

  always @(posedge clk) begin
    if (rd_pulse) cnt_rd++;
    if (cfg_wr)   cnt_cfg++;
    if (gc_reset) cnt_gc++;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1; wc(H); scl_m = 1; wc(H); sda_m = 0; wc(H); scl_m = 0; wc(2);
  endtask

  task automatic bus_stop();
    sda_m = 0; wc(H); scl_m = 1; wc(H); sda_m = 1; wc(H);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; wc(H); scl_m = 1; wc(H); scl_m = 0; wc(1);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic nak);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1; wc(H); scl_m = 1; wc(H/2); nak = sda_line; wc(H/2); scl_m = 0; wc(1);
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic nak);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      wc(H); scl_m = 1; wc(H/2); b[i] = sda_line; wc(H/2); scl_m = 0; wc(1);
    end
    send_bit(nak);
  endtask

  task automatic wr_reg(input logic [1:0] p, input logic [15:0] d, output logic ok);
    logic n0, n1, n2, n3;
    bus_start();
    send_byte({dev_addr, 1'b0}, n0);
    send_byte({6'b0, p}, n1);
    send_byte(d[15:8], n2);
    n3 = 1'b0;
    if (p != 2'd1) send_byte(d[7:0], n3);
    bus_stop();
    ok = !(n0 | n1 | n2 | n3);
  endtask

  task automatic rd_reg(output logic [15:0] v);
    logic n0;
    logic [7:0] m, l;
    bus_start();
    send_byte({dev_addr, 1'b1}, n0);
    recv_byte(m, 1'b0);
    recv_byte(l, 1'b1);
    bus_stop();
    v = {m, l};
  endtask

  task automatic gen_call(input logic [7:0] cmd, output logic ok);
    logic n0, n1;
    bus_start();
    send_byte(8'h00, n0);
    send_byte(cmd, n1);
    bus_stop();
    ok = !(n0 | n1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin : main
    logic ok, nak;
    logic [15:0] v;
    logic [7:0] m, l;
    int c0;
    wc(5); rst = 0; wc(5);

    // R8 power-up values, bus released
    chk("R8 cfg reset", cfg, 8'h00);
    chk("R8 tlow reset", tlow, 12'h4B0);
    chk("R8 thigh reset", thigh, 12'h500);
    chk("R5 sda released after reset", sda_oe, 0);

    // R2 pointer resets to temperature
    rd_reg(v);
    chk("R2 reset pointer reads temperature", v, 16'h1900);

    // table of write/readback vectors (R4 R6 R7)
    for (int i = 0; i < NV; i++) begin
      c0 = cnt_cfg;
      wr_reg(VEC[i][33:32], VEC[i][31:16], ok);
      chk("R5 write bytes acknowledged", ok, 1);
      rd_reg(v);
      chk("R4 R6 R7 readback word", v, VEC[i][15:0]);
      chk("R7 cfg_wr strobe count", cnt_cfg - c0, (VEC[i][33:32] == 2'd1) ? 1 : 0);
    end
    chk("R7 cfg port", cfg, 8'h05);
    chk("R4 tlow port", tlow, 12'hC90);
    chk("R4 thigh port", thigh, 12'hE70);

    // R3 repeated reads reuse pointer; R10 one pulse per byte
    c0 = cnt_rd;
    rd_reg(v);
    chk("R3 repeat read 1", v, 16'hC900);
    rd_reg(v);
    chk("R3 repeat read 2", v, 16'hC900);
    chk("R10 read pulses", cnt_rd - c0, 4);
    chk("R5 released after master NACK", sda_oe, 0);

    // R1 wrong address
    bus_start();
    send_byte({7'h4A, 1'b0}, nak);
    bus_stop();
    chk("R1 foreign address not acknowledged", nak, 1);
    chk("R1 sda released", sda_oe, 0);

    // R1 address pin latched at START
    addr_pin = 1;
    bus_start();
    send_byte({7'h48, 1'b1}, nak);
    bus_stop();
    chk("R1 old address rejected after pin change", nak, 1);
    dev_addr = 7'h49;
    rd_reg(v);
    chk("R1 new address answers", v, 16'hC900);
    addr_pin = 0;
    dev_addr = 7'h48;

    // R6 snapshot across a temperature change
    wr_reg(2'd0, 16'h0000, ok);
    bus_start();
    send_byte({dev_addr, 1'b1}, nak);
    recv_byte(m, 1'b0);
    temp = 12'h7FF;
    recv_byte(l, 1'b1);
    bus_stop();
    chk("R6 snapshot word", {m, l}, 16'h1900);
    rd_reg(v);
    chk("R6 new temperature visible", v, 16'h7FF0);

    // R8 general-call latch keeps registers
    c0 = cnt_gc;
    gen_call(8'h04, ok);
    chk("R8 latch command acknowledged", ok, 1);
    chk("R8 latch keeps tlow", tlow, 12'hC90);
    chk("R8 latch no reset strobe", cnt_gc - c0, 0);

    // R8 general-call reset
    gen_call(8'h06, ok);
    chk("R8 reset strobe", cnt_gc - c0, 1);
    chk("R8 cfg restored", cfg, 8'h00);
    chk("R8 tlow restored", tlow, 12'h4B0);
    chk("R8 thigh restored", thigh, 12'h500);
    rd_reg(v);
    chk("R2 R8 pointer cleared by reset", v, 16'h7FF0);

    // R9 stuck SCL low during acknowledge
    bus_start();
    for (int i = 7; i >= 0; i--) send_bit(dev_addr_bit(i));
    wc(6);
    chk("R5 address ack driven", sda_oe, 1);
    wc(TO + 20);
    chk("R9 sda released after timeout", sda_oe, 0);
    sda_m = 1; wc(H); scl_m = 1; wc(H);
    rd_reg(v);
    chk("R9 recovery transaction", v, 16'h7FF0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  function automatic logic dev_addr_bit(input int i);
    logic [7:0] b;
    b = {dev_addr, 1'b0};
    return b[i];
  endfunction
endmodule